// File: doc/BRIEF.md
# Segment Descriptor Address Unit

The unit turns a 32-bit logical offset into a 32-bit linear address. It does this through one of several segment registers. Each segment register caches a 64-bit descriptor, which is loaded through a plain write port. For every request the unit gathers the base and limit fields that are scattered across the descriptor. It scales the limit by the granularity flag and compares the offset against that limit. It then adds the base to the offset to form the linear address.

Every access uses a segment; segmentation cannot be switched off. A request names no segment by default, and the fixed default segment register is used. An override input replaces it with an explicit segment register. A flat segment has base zero, a 20-bit limit of all ones and the granularity flag set. Such a segment reaches the whole 4 GiB linear space unchanged.

The result is registered. One cycle after each request the unit raises exactly one of two flags: a valid flag together with the address, or a fault flag.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `vld` and `flt` are 0 and `lin_addr` is 0. Every cached descriptor reads as all zeros, so an access made before any write faults.
- R2: When `wr_en` is high, `wr_desc` is stored into segment register `wr_sel` at the clock edge. A request made in that same cycle still sees the old contents. Requests from the next cycle on see the new contents.
- R3: The segment used is `ovr_sel` when `ovr_en` is 1, and parameter `DFLT_SEG` otherwise. A segment number of `NSEG` or above always faults, and a write to such a number has no effect.
- R4: The 32-bit base is formed from descriptor bits [63:56] as base[31:24], bits [39:32] as base[23:16] and bits [31:16] as base[15:0].
- R5: The 20-bit limit is formed from descriptor bits [51:48] as limit[19:16] and bits [15:0] as limit[15:0]. With the granularity bit (bit 55) at 0, the effective limit is this value zero-extended.
- R6: With the granularity bit at 1, the effective limit is {limit, 12'hFFF}. A flat segment therefore accepts every offset from 0 to 0xFFFFFFFF.
- R7: An offset equal to the effective limit is accepted. An offset above it faults.
- R8: A descriptor whose present bit (bit 47) is 0 faults for every offset.
- R9: A descriptor whose must-be-zero bit (bit 53) is 1 faults for every offset.
- R10: On an accepted request, `lin_addr` equals offset + base modulo 2^32.
- R11: `vld` or `flt` is high in the cycle after a request and in no other cycle. Exactly one of the two is high.
- R12: On a fault, `lin_addr` is 0. With no request, `lin_addr` keeps its value. Descriptor bits [46:40], 52 and 54 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Descriptor write strobe |
| wr_sel | input | SW | Segment register to write |
| wr_desc | input | 64 | Descriptor to store |
| req | input | 1 | Translation request strobe |
| ovr_en | input | 1 | Use `ovr_sel` instead of the default segment |
| ovr_sel | input | SW | Override segment number |
| req_off | input | 32 | Logical offset |
| vld | output | 1 | Translation accepted, address valid |
| flt | output | 1 | Translation faulted |
| lin_addr | output | 32 | Linear address |

## Verification
The assertions check the handshake shape on every cycle:
- exactly one outcome follows each request,
- no outcome appears without a request,
- a faulted result carries a zero address,
- the address holds while the unit is idle.

Field assembly, granularity scaling, the limit boundary, the write-then-read ordering and segment selection depend on descriptor contents that only the bench knows. These are shown by its sweeps, which cover offsets at and around each segment's effective limit across all segment registers.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int NSEG = 6,
  parameter int DFLT_SEG = 3,
  localparam int SW = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sel,
  input  logic [63:0]   wr_desc,
  input  logic          req,
  input  logic          ovr_en,
  input  logic [SW-1:0] ovr_sel,
  input  logic [31:0]   req_off,
  output logic          vld,
  output logic          flt,
  output logic [31:0]   lin_addr
);

  logic [63:0] dtab [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        dtab[g] <= '0;
      else if (wr_en && wr_sel == SW'(g))
        dtab[g] <= wr_desc;
    end
  end

  logic [SW-1:0] seg;
  logic          seg_ok;
  logic [63:0]   desc;

  assign seg    = ovr_en ? ovr_sel : SW'(DFLT_SEG);
  assign seg_ok = {1'b0, seg} < (SW+1)'(NSEG);

  always_comb begin
    desc = '0;
    for (int i = 0; i < NSEG; i++)
      if (seg == SW'(i)) desc = dtab[i];
  end

  logic [31:0] base;
  logic [19:0] lim20;
  logic [31:0] eff_lim;
  logic        bad;

  assign base    = {desc[63:56], desc[39:32], desc[31:16]};
  assign lim20   = {desc[51:48], desc[15:0]};
  assign eff_lim = desc[55] ? {lim20, 12'hFFF} : {12'h000, lim20};
  assign bad     = !seg_ok || !desc[47] || desc[53] || (req_off > eff_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld      <= 1'b0;
      flt      <= 1'b0;
      lin_addr <= '0;
    end else begin
      vld <= req && !bad;
      flt <= req && bad;
      if (req) lin_addr <= bad ? 32'h0 : req_off + base;
    end
  end

endmodule

module seg_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req,
  input logic        vld,
  input logic        flt,
  input logic [31:0] lin_addr
);

  a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(vld && flt));

  a_r11_only_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    (vld || flt) |-> $past(req));

  a_r11_req_answered: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> (vld || flt));

  a_r12_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    flt |-> lin_addr == 32'h0);

  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> $stable(lin_addr));

endmodule

bind seg_xlate seg_xlate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .vld(vld), .flt(flt), .lin_addr(lin_addr)
);

// File: tb/test_seg_xlate.sv
`timescale 1ns/1ps
module test_seg_xlate;
  localparam int NSEG = 6;
  localparam int DFLT = 3;
  localparam int SW = 3;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, req = 0, ovr_en = 0;
  logic [SW-1:0] wr_sel = 0, ovr_sel = 0;
  logic [63:0] wr_desc = 0;
  logic [31:0] req_off = 0;
  logic vld, flt;
  logic [31:0] lin_addr;

  int nvec = 0, nbad = 0;
  bit done = 0;
  logic [63:0] mdl [8];

  always #2 clk = ~clk;

  seg_xlate #(.NSEG(NSEG), .DFLT_SEG(DFLT)) i_seg_xlate (.*);

  function automatic logic [63:0] mk(input logic [31:0] b, input logic [19:0] l,
      input logic g, input logic p, input logic mbz, input logic [6:0] attr, input logic d, input logic u);
    return {b[31:24], g, d, mbz, u, l[19:16], p, attr, b[23:16], b[15:0], l[15:0]};
  endfunction

  task automatic chk(input string r, input logic [33:0] act, input logic [33:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got vld/flt/addr=%h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(input int s, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = SW'(s); wr_desc = d;
    @(negedge clk);
    wr_en = 0;
    if (s < NSEG) mdl[s] = d;
  endtask

  function automatic logic [33:0] expect_of(input int s, input logic [31:0] off);
    logic [63:0] d;
    logic [31:0] b, e;
    logic [19:0] l;
    if (s >= NSEG) return {2'b01, 32'h0};
    d = mdl[s];
    b = {d[63:56], d[39:32], d[31:16]};
    l = {d[51:48], d[15:0]};
    e = d[55] ? {l, 12'hFFF} : {12'h0, l};
    if (!d[47] || d[53] || off > e) return {2'b01, 32'h0};
    return {2'b10, off + b};
  endfunction

  task automatic acc(input string r, input logic ov, input int s, input logic [31:0] off);
    logic [33:0] e;
    int es;
    es = ov ? s : DFLT;
    e = expect_of(es, off);
    @(negedge clk);
    req = 1; ovr_en = ov; ovr_sel = SW'(s); req_off = off;
    @(negedge clk);
    req = 0;
    chk(r, {vld, flt, lin_addr}, e);
    @(negedge clk);
    chk("R11/R12 idle", {vld, flt, lin_addr}, {2'b00, e[31:0]});
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    #7;
    chk("R1 reset", {vld, flt, lin_addr}, 34'h0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset", {vld, flt, lin_addr}, 34'h0);
    acc("R1 empty desc", 0, 0, 32'h10);

    wr(DFLT, mk(32'h0, 20'hFFFFF, 1, 1, 0, 7'h1B, 1, 0));
    acc("R6 flat low", 0, 5, 32'h0);
    acc("R6 flat high", 0, 5, 32'hFFFF_FFFF);
    acc("R10 flat mid", 0, 1, 32'h1234_5678);
    acc("R3 override", 1, DFLT, 32'h0000_4000);

    for (int s = 0; s < NSEG; s++) begin
      logic [31:0] b, e;
      logic [19:0] l;
      logic g;
      b = 32'h1000_0000 * s + 32'h0123_4567;
      l = 20'h00FFF + 20'h11111 * s;
      g = s[0];
      wr(s, mk(b, l, g, 1, 0, 7'(s * 19), s[1], s[2]));
      e = g ? {l, 12'hFFF} : {12'h0, l};
      acc("R4/R5/R6 zero off", 1, s, 32'h0);
      acc("R7 below limit", 1, s, e - 1);
      acc("R7 at limit", 1, s, e);
      acc("R7 above limit", 1, s, e + 1);
      acc("R7 max off", 1, s, 32'hFFFF_FFFF);
      acc("R3 default seg", 0, s, e >> 1);
    end

    wr(2, mk(32'h0040_0000, 20'h0FFFF, 0, 0, 0, 7'h00, 0, 0));
    acc("R8 not present", 1, 2, 32'h0);
    acc("R8 not present mid", 1, 2, 32'h100);
    wr(4, mk(32'h0040_0000, 20'h0FFFF, 0, 1, 1, 7'h00, 0, 0));
    acc("R9 mbz set", 1, 4, 32'h0);

    wr(7, mk(32'h0, 20'hFFFFF, 1, 1, 0, 0, 0, 0));
    acc("R3 out of range 7", 1, 7, 32'h0);
    acc("R3 out of range 6", 1, 6, 32'h0);
    acc("R3 write ignored check", 1, 0, 32'h10);

    wr(1, mk(32'hFFFF_F000, 20'hFFFFF, 1, 1, 0, 7'h7F, 1, 1));
    acc("R10 wrap", 1, 1, 32'h0000_2000);
    acc("R12 attrs ignored", 1, 1, 32'h0000_0FFF);

    wr(0, mk(32'h0000_1000, 20'h00100, 0, 1, 0, 0, 0, 0));
    @(negedge clk);
    wr_en = 1; wr_sel = 0; wr_desc = mk(32'h0002_0000, 20'h00100, 0, 1, 0, 0, 0, 0);
    req = 1; ovr_en = 1; ovr_sel = 0; req_off = 32'h20;
    @(negedge clk);
    wr_en = 0; req = 0;
    chk("R2 same-cycle old desc", {vld, flt, lin_addr}, {2'b10, 32'h0000_1020});
    mdl[0] = mk(32'h0002_0000, 20'h00100, 0, 1, 0, 0, 0, 0);
    acc("R2 new desc", 1, 0, 32'h20);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule